// File: doc/BRIEF.md
# I2C Controller Event Status and Interrupt Vector Unit

This unit collects the event pulses of an I2C controller into sticky status flags, masks them with an interrupt enable word and drives one interrupt line. A protocol engine and its FIFOs supply single-cycle event pulses, and software reaches the flags over a simple register port with an address, a write strobe, a read strobe and 16-bit data. Software acknowledges any subset of flags by writing ones to the status word. Bits written as zero are left alone.

A second way in suits simpler interrupt handlers. A vector word returns a small code for the most urgent pending and enabled event among the five main ones. A read strobe on that word clears the flag it reported. The bus-busy flag is different from the others: it shows the live bus state, so it is never latched and never cleared by software.

Top module: `i2c_event_irq`

## Requirements
- R1: An event pulse on a latching status bit sets that bit on the next clock edge, and the bit stays set until it is cleared. The latching bits are 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 8 address zero, 9 addressed as slave, 10 transmit underflow, 11 receive overrun, 13 receive drain and 14 transmit drain.
- R2: A write to the status word (address 1) clears every latching bit whose write-data bit is 1 and leaves every bit written as 0 unchanged.
- R3: If an event pulse and a clearing write reach the same bit in one cycle, the bit is set afterwards.
- R4: Status bit 12 always reads as the current bus_busy input. It is not latched and a clearing write has no effect on it.
- R5: The enable word (address 0) stores write-data bits 0 to 4, 13 and 14. All its other bits read as 0.
- R6: irq equals the OR of (status AND enable) as it stood one clock edge earlier.
- R7: A read of the vector word (address 2) returns one of six codes. 0 means nothing is pending, 1 is arbitration lost, 2 is no-acknowledge, 3 is access ready, 4 is receive ready and 5 is transmit ready. Only enabled status bits 0 to 4 count, and the lowest nonzero code wins.
- R8: A vector access with reg_rd high clears the one status bit that was reported, on the next edge. Accessing the vector word without reg_rd clears nothing.
- R9: Event pulses on status bits 5, 6, 7 and 15 are ignored, and those bits read as 0.
- R10: After reset the status, enable and irq all read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 16 | Event pulses, one per status bit position |
| bus_busy | input | 1 | Live bus-busy level |
| reg_addr | input | ADDR_W | Register select: 0 enable, 1 status, 2 vector |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears the reported flag on a vector access) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets four corner cases. In the first, a pulse and a clearing write land on the same bit together; a design where the clear wins would lose that event. In the second, vector codes are read with a lower-code event masked off; a design that skips the enable mask, or uses the wrong priority order, would return the wrong code. In the third, the vector word is accessed with and without the read strobe; a design that clears on a plain access, or clears the wrong bit, would lose flags. The bench also times irq to the exact cycle to expose a missing or extra register stage, and writes a one to the bus-busy position to catch a design that latches or clears it.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned VEC_SRCS = 5;
  localparam int unsigned VEC_W    = $clog2(VEC_SRCS + 1);
  localparam int unsigned BUSY_BIT = 12;
  // status bits that latch an event pulse
  localparam logic [REG_W-1:0] LATCH_MASK  = 16'h6F1F;
  // status bits that can raise the interrupt
  localparam logic [REG_W-1:0] ENABLE_MASK = 16'h601F;
endpackage

// File: rtl/i2c_evt_sticky.sv
module i2c_evt_sticky #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic unused_in;
  assign unused_in = ^((set_i | clr_i) & ~KEEP);

  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    if (KEEP[gi]) begin : g_flop
      logic ce;
      logic d;
      logic q;
      // a set always beats a clear in the same cycle
      always_comb begin
        ce = set_i[gi] | clr_i[gi];
        d  = set_i[gi];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (ce) q <= d;
      end
      assign q_o[gi] = q;
    end else begin : g_void
      assign q_o[gi] = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_enable.sv
module i2c_evt_enable #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] en_d;
  logic [W-1:0] en_q;

  always_comb en_d = wdata_i & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end

  assign q_o = en_q;
endmodule

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio #(
  parameter int unsigned N  = 5,
  parameter int unsigned CW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic [CW-1:0] code_o
);
  // the lowest index wins, and the code is the index plus one
  always_comb begin
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) code_o = CW'(i + 1);
    end
  end
endmodule

// File: rtl/i2c_event_irq.sv
module i2c_event_irq
  import i2c_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 0,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = 1,
  parameter logic [ADDR_W-1:0] ADDR_VECTOR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  evt_pulse,
  input  logic              bus_busy,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq
);
  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_q;
  logic [VEC_W-1:0] vec_code;
  logic [REG_W-1:0] clr_w1c;
  logic [REG_W-1:0] clr_rd;
  logic [REG_W-1:0] clr_all;
  logic             en_wr;
  logic             irq_d;
  logic             irq_q;

  always_comb begin
    en_wr   = reg_wr && (reg_addr == ADDR_ENABLE);
    clr_w1c = (reg_wr && (reg_addr == ADDR_STATUS)) ? (reg_wdata & LATCH_MASK) : '0;
    clr_rd  = '0;
    if (reg_rd && (reg_addr == ADDR_VECTOR) && (vec_code != '0))
      clr_rd = REG_W'(1) << (vec_code - VEC_W'(1));
    clr_all = clr_w1c | clr_rd;
  end

  i2c_evt_sticky #(.W(REG_W), .KEEP(LATCH_MASK)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_pulse),
    .clr_i (clr_all),
    .q_o   (sts_q)
  );

  i2c_evt_enable #(.W(REG_W), .MASK(ENABLE_MASK)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr),
    .wdata_i (reg_wdata),
    .q_o     (en_q)
  );

  i2c_evt_prio #(.N(VEC_SRCS), .CW(VEC_W)) u_prio (
    .pend_i (sts_q[VEC_SRCS-1:0] & en_q[VEC_SRCS-1:0]),
    .code_o (vec_code)
  );

  always_comb irq_d = |(sts_q & en_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_ENABLE) begin
      reg_rdata = en_q;
    end else if (reg_addr == ADDR_STATUS) begin
      reg_rdata = sts_q;
      reg_rdata[BUSY_BIT] = bus_busy;
    end else if (reg_addr == ADDR_VECTOR) begin
      reg_rdata = REG_W'(vec_code);
    end
  end
endmodule

// File: rtl/i2c_event_irq_chk.sv
module i2c_event_irq_chk
  import i2c_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] ADDR_ENABLE = 0,
  parameter logic [ADDR_W-1:0] ADDR_STATUS = 1,
  parameter logic [ADDR_W-1:0] ADDR_VECTOR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  evt_pulse,
  input logic              bus_busy,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq,
  input logic [REG_W-1:0]  sts_q,
  input logic [REG_W-1:0]  en_q
);
  logic [REG_W-1:0] rc_hit;
  always_comb begin
    rc_hit = '0;
    if (reg_rdata[VEC_W-1:0] != '0)
      rc_hit = REG_W'(1) << (reg_rdata[VEC_W-1:0] - VEC_W'(1));
  end

  for (genvar gi = 0; gi < REG_W; gi++) begin : g_bit
    if (LATCH_MASK[gi]) begin : g_latch
      assert_sticky_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse[gi] |=> sts_q[gi]);
      assert_w1c_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STATUS && reg_wdata[gi] && !evt_pulse[gi]) |=> !sts_q[gi]);
      assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STATUS && reg_wdata[gi] && evt_pulse[gi]) |=> sts_q[gi]);
    end
  end

  assert_busy_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_STATUS) |-> (reg_rdata[BUSY_BIT] == bus_busy));

  assert_enable_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_ENABLE) |-> ((reg_rdata & ~ENABLE_MASK) == '0));

  assert_irq_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(sts_q & en_q))));

  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_VECTOR) |-> (reg_rdata <= REG_W'(VEC_SRCS)));

  assert_vec_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_VECTOR && ((evt_pulse & rc_hit) == '0)) |=> ((sts_q & $past(rc_hit)) == '0));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_STATUS) |-> ((reg_rdata & ~(LATCH_MASK | (REG_W'(1) << BUSY_BIT))) == '0));
endmodule

bind i2c_event_irq i2c_event_irq_chk #(
  .ADDR_W(ADDR_W), .ADDR_ENABLE(ADDR_ENABLE), .ADDR_STATUS(ADDR_STATUS), .ADDR_VECTOR(ADDR_VECTOR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_pulse (evt_pulse),
  .bus_busy  (bus_busy),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .sts_q     (sts_q),
  .en_q      (en_q)
);

// File: tb/i2c_event_irq_test.sv
module i2c_event_irq_test;
  localparam logic [1:0] A_EN  = 2'd0;
  localparam logic [1:0] A_ST  = 2'd1;
  localparam logic [1:0] A_VEC = 2'd2;

  logic        clk;
  logic        rst_n;
  logic [15:0] evt_pulse;
  logic        bus_busy;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  i2c_event_irq uut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    peek(A_ST, v);  check("R10 status", v, 16'h0000);
    peek(A_EN, v);  check("R10 enable", v, 16'h0000);
    check("R10 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_sticky;
    logic [15:0] v;
    pulse(16'hEFFF);
    peek(A_ST, v); check("R1 R9 latch all", v, 16'h6F1F);
    repeat (3) @(negedge clk);
    peek(A_ST, v); check("R1 held", v, 16'h6F1F);
  endtask

  task automatic t_w1c;
    logic [15:0] v;
    reg_write(A_ST, 16'h0103);
    peek(A_ST, v); check("R2 subset clear", v, 16'h6E1C);
    reg_write(A_ST, 16'h0000);
    peek(A_ST, v); check("R2 zero write", v, 16'h6E1C);
  endtask

  task automatic t_busy;
    logic [15:0] v;
    @(negedge clk); bus_busy = 1'b1;
    peek(A_ST, v); check("R4 busy live high", v, 16'h7E1C);
    reg_write(A_ST, 16'h1000);
    peek(A_ST, v); check("R4 busy ignores clear", v, 16'h7E1C);
    bus_busy = 1'b0;
    peek(A_ST, v); check("R4 busy not latched", v, 16'h6E1C);
  endtask

  task automatic t_set_wins;
    logic [15:0] v;
    reg_write(A_ST, 16'h0008);
    peek(A_ST, v); check("R2 bit3 cleared", v & 16'h0008, 16'h0000);
    @(negedge clk);
    reg_addr = A_ST; reg_wdata = 16'h0008; reg_wr = 1'b1; evt_pulse = 16'h0008;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
    peek(A_ST, v); check("R3 set beats clear", v & 16'h0008, 16'h0008);
  endtask

  task automatic t_enable;
    logic [15:0] v;
    reg_write(A_EN, 16'hFFFF);
    peek(A_EN, v); check("R5 enable mask", v, 16'h601F);
  endtask

  task automatic t_irq;
    reg_write(A_EN, 16'h0002);
    reg_write(A_ST, 16'hFFFF);
    @(negedge clk);
    check("R6 idle low", {15'd0, irq}, 16'h0000);
    pulse(16'h0001);
    @(negedge clk);
    check("R6 masked event", {15'd0, irq}, 16'h0000);
    pulse(16'h0002);
    check("R6 one cycle late", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    check("R6 raised", {15'd0, irq}, 16'h0001);
    reg_write(A_ST, 16'h0002);
    check("R6 falls late", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    check("R6 dropped", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_vector;
    logic [15:0] v;
    reg_write(A_EN, 16'h001F);
    reg_write(A_ST, 16'hFFFF);
    peek(A_VEC, v); check("R7 none", v, 16'd0);
    pulse(16'h0014);
    peek(A_VEC, v); check("R7 priority", v, 16'd3);
    @(negedge clk);
    peek(A_VEC, v); check("R8 plain access keeps", v, 16'd3);
    reg_read(A_VEC, v); check("R7 read code", v, 16'd3);
    peek(A_ST, v); check("R8 only reported bit cleared", v, 16'h0010);
    reg_read(A_VEC, v); check("R7 transmit ready", v, 16'd5);
    peek(A_ST, v); check("R8 cleared second", v, 16'h0000);
    reg_read(A_VEC, v); check("R7 empty", v, 16'd0);
    reg_write(A_EN, 16'h001E);
    pulse(16'h0009);
    reg_read(A_VEC, v); check("R7 masked low code", v, 16'd4);
    peek(A_ST, v); check("R8 masked bit kept", v, 16'h0001);
    peek(A_VEC, v); check("R7 masked gives none", v, 16'd0);
  endtask

  initial begin
    rst_n = 1'b0; evt_pulse = '0; bus_busy = 1'b0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_sticky();
    t_w1c();
    t_busy();
    t_set_wins();
    t_enable();
    t_irq();
    t_vector();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule